// File: doc/BRIEF.md
# LDPC Iteration Stop Controller with CRC-Aided Early Exit

This block decides when a layered LDPC decoder may stop iterating on one codeword. At the end of every decoding iteration the decoder reports how many parity-check equations are still unsatisfied. If none fail, decoding ends. If a few fail, below a fixed threshold, the controller opens a window. In that window it takes the serial hard-decision bits of the information part of the codeword and runs a 32-bit CRC over them. A matching CRC ends decoding even though some parity checks are still unsatisfied. If neither exit is taken, decoding ends once the configured iteration limit is reached.

The information part is K bits long. Its last 32 bits carry the CRC of the K-32 bits ahead of them. K is chosen per codeword from eight sizes by a rate code, and the rate code is captured when a codeword starts. The outputs are a held stop flag, a two-bit reason code and the count of completed iterations. The decoder datapath and the evaluation of the parity checks sit outside this block.

Top module: `ldpc_stop_ctrl`

## Requirements
- R1: After reset, and in the cycle after `start_i`, `stop_o` is 0, `reason_o` is 00 and `iter_o` is 0.
- R2: A failure report (`fail_valid_i`) taken while the block is neither stopped nor inside a CRC window raises `iter_o` by exactly one. `iter_o` never moves by more than one per cycle.
- R3: A report with `fail_count_i` equal to 0 sets `stop_o` with reason 00 on the next clock edge. No CRC window is opened.
- R4: A report with `fail_count_i` from 1 to FAIL_LIMIT-1 (default 50) opens a CRC window that takes the next K accepted bits. A count of FAIL_LIMIT or more opens no window.
- R5: Inside a window, the CRC register starts at all ones. It is updated MSB-first over the first K-32 bits with polynomial 0x04C11DB7, with no reflection and no final inversion. The last 32 bits form the received CRC, and the first of them received is its bit 31. If the two are equal, `stop_o` rises with reason 01 no later than two cycles after the edge that takes the last bit.
- R6: K equals BLK_BITS times 30, 36, 40, 45, 48, 50, 52 or 54 for `rate_i` 0 to 7. With the default BLK_BITS of 256 this gives 7680 to 13824 bits. The rate code is captured on `start_i`.
- R7: When the completed-iteration count reaches `max_iter_i` without an earlier exit, `stop_o` rises with reason 10. This happens either at that iteration's report or, if that iteration opened a window, when the CRC mismatches. The stop never comes earlier. A limit of 0 behaves as a limit of 1.
- R8: Once stopped, `stop_o`, `reason_o` and `iter_o` hold until `start_i`. Further failure reports and bits have no effect.
- R9: Bits presented outside a CRC window are ignored and do not disturb a later window's CRC.
- R10: A CRC mismatch below the iteration limit returns the block to waiting for the next report without stopping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a new codeword and captures the rate code |
| rate_i | input | 3 | Rate code selecting K |
| max_iter_i | input | ITER_W | Iteration limit |
| fail_valid_i | input | 1 | End-of-iteration failure report strobe |
| fail_count_i | input | FAIL_W | Number of unsatisfied parity checks |
| bit_valid_i | input | 1 | Hard-decision bit strobe |
| bit_i | input | 1 | Hard-decision bit, information part first bit first |
| stop_o | output | 1 | Decoding may stop (held) |
| reason_o | output | 2 | 00 all checks pass, 01 CRC match, 10 iteration limit |
| iter_o | output | ITER_W | Completed iterations |

## Verification
The hardest situation to reach is a CRC window that closes on its very last bit, for every one of the eight K values. It must close both with a correct CRC and with one wrong bit, and both when the limit has been reached and when it has not. The bench uses a reduced block size so that every rate code fits in a short run. It builds payloads from its own pseudo-random generator, computes their CRC arithmetically, and appends it either intact or with one bit flipped. It also sends stray bits before the window opens, and it sweeps the failure count across the threshold boundary and the limit from 1 upward.

// File: rtl/ldpc_stop_pkg.sv
package ldpc_stop_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        RSN_PARITY = 2'b00,
        RSN_CRC    = 2'b01,
        RSN_LIMIT  = 2'b10
    } reason_e;

    typedef enum logic [1:0] {
        ST_WAIT = 2'b00,
        ST_CRC  = 2'b01,
        ST_STOP = 2'b10
    } state_e;

    typedef struct packed {
        logic    stop;
        reason_e reason;
    } verdict_t;

    // information length in units of BLK_BITS for each rate code
    function automatic int unsigned k_units(input logic [2:0] rate);
        case (rate)
            3'd0:    return 30;
            3'd1:    return 36;
            3'd2:    return 40;
            3'd3:    return 45;
            3'd4:    return 48;
            3'd5:    return 50;
            3'd6:    return 52;
            default: return 54;
        endcase
    endfunction

    // one serial MSB-first step of the CRC register
    function automatic logic [31:0] crc_step(input logic [31:0] cur, input logic din);
        logic fb;
        fb = cur[31] ^ din;
        return {cur[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    endfunction

endpackage

// File: rtl/ldpc_stop_crc32.sv
module ldpc_stop_crc32
    import ldpc_stop_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        clr_i,
    input  logic        en_i,
    input  logic        bit_i,
    output logic [31:0] crc_o
);
    logic [31:0] crc_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            crc_q <= CRC_INIT;
        end else if (en_i) begin
            crc_q <= crc_step(crc_q, bit_i);
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/ldpc_stop_frame.sv
module ldpc_stop_frame
    import ldpc_stop_pkg::*;
#(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] k_len_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic             done_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      rx_q;
    logic [31:0]      crc_w;
    logic             done_q;
    logic             open_q;
    logic             in_payload;
    logic             last_bit;

    assign in_payload = ({1'b0, cnt_q} + 33'd32) < {1'b0, k_len_i};
    assign last_bit   = cnt_q == (k_len_i - 1'b1);

    ldpc_stop_crc32 crc_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (clr_i),
        .en_i  (en_i && open_q && in_payload),
        .bit_i (bit_i),
        .crc_o (crc_w)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            done_q <= 1'b0;
            open_q <= clr_i;
        end else begin
            done_q <= 1'b0;
            if (en_i && open_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (!in_payload) begin
                    rx_q <= {rx_q[30:0], bit_i};
                end
                if (last_bit) begin
                    done_q <= 1'b1;
                    open_q <= 1'b0;
                end
            end
        end
    end

    assign done_o  = done_q;
    assign match_o = crc_w == rx_q;
endmodule

// File: rtl/ldpc_stop_iter.sv
module ldpc_stop_iter #(
    parameter int unsigned ITER_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [ITER_W-1:0] cnt_o
);
    logic [ITER_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/ldpc_stop_ctrl.sv
module ldpc_stop_ctrl
    import ldpc_stop_pkg::*;
#(
    parameter int unsigned BLK_BITS   = 256,
    parameter int unsigned ITER_W     = 6,
    parameter int unsigned FAIL_W     = 12,
    parameter int unsigned FAIL_LIMIT = 50
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [2:0]        rate_i,
    input  logic [ITER_W-1:0] max_iter_i,
    input  logic              fail_valid_i,
    input  logic [FAIL_W-1:0] fail_count_i,
    input  logic              bit_valid_i,
    input  logic              bit_i,
    output logic              stop_o,
    output logic [1:0]        reason_o,
    output logic [ITER_W-1:0] iter_o
);
    localparam int unsigned K_MAX = 54 * BLK_BITS;
    localparam int unsigned CNT_W = $clog2(K_MAX + 1);

    state_e           state_q;
    verdict_t         verdict_q;
    logic [CNT_W-1:0] k_len_q;
    logic [ITER_W-1:0] iter_w;
    logic [ITER_W:0]  iter_next;
    logic             take_report;
    logic             open_win;
    logic             crc_done;
    logic             crc_match;
    logic             at_limit_next;
    logic             at_limit_now;

    assign take_report   = (state_q == ST_WAIT) && fail_valid_i && !start_i;
    assign iter_next     = {1'b0, iter_w} + 1'b1;
    assign at_limit_next = iter_next >= {1'b0, max_iter_i};
    assign at_limit_now  = (iter_w >= max_iter_i);
    assign open_win      = take_report && (fail_count_i != '0)
                         && (fail_count_i < FAIL_W'(FAIL_LIMIT));

    ldpc_stop_iter #(.ITER_W(ITER_W)) iter_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (start_i),
        .inc_i (take_report),
        .cnt_o (iter_w)
    );

    ldpc_stop_frame #(.CNT_W(CNT_W)) frame_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (open_win),
        .k_len_i (k_len_q),
        .en_i    (bit_valid_i && (state_q == ST_CRC)),
        .bit_i   (bit_i),
        .done_o  (crc_done),
        .match_o (crc_match)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            k_len_q <= CNT_W'(k_units(3'd0) * BLK_BITS);
        end else if (start_i) begin
            k_len_q <= CNT_W'(k_units(rate_i) * BLK_BITS);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || start_i) begin
            state_q   <= ST_WAIT;
            verdict_q <= '{stop: 1'b0, reason: RSN_PARITY};
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (fail_valid_i) begin
                        if (fail_count_i == '0) begin
                            state_q   <= ST_STOP;
                            verdict_q <= '{stop: 1'b1, reason: RSN_PARITY};
                        end else if (open_win) begin
                            state_q <= ST_CRC;
                        end else if (at_limit_next) begin
                            state_q   <= ST_STOP;
                            verdict_q <= '{stop: 1'b1, reason: RSN_LIMIT};
                        end
                    end
                end
                ST_CRC: begin
                    if (crc_done) begin
                        if (crc_match) begin
                            state_q   <= ST_STOP;
                            verdict_q <= '{stop: 1'b1, reason: RSN_CRC};
                        end else if (at_limit_now) begin
                            state_q   <= ST_STOP;
                            verdict_q <= '{stop: 1'b1, reason: RSN_LIMIT};
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                default: state_q <= ST_STOP;
            endcase
        end
    end

    assign stop_o   = verdict_q.stop;
    assign reason_o = verdict_q.reason;
    assign iter_o   = iter_w;
endmodule

// File: rtl/ldpc_stop_ctrl_chk.sv
module ldpc_stop_ctrl_chk #(
    parameter int unsigned ITER_W = 6,
    parameter int unsigned FAIL_W = 12
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              start_i,
    input logic [ITER_W-1:0] max_iter_i,
    input logic              fail_valid_i,
    input logic [FAIL_W-1:0] fail_count_i,
    input logic              stop_o,
    input logic [1:0]        reason_o,
    input logic [ITER_W-1:0] iter_o
);
    // R1
    start_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (!stop_o && iter_o == '0 && reason_o == 2'b00));

    // R2
    iter_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> (iter_o == $past(iter_o) || iter_o == $past(iter_o) + 1'b1));

    // R3
    parity_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(stop_o) && reason_o == 2'b00) |-> $past(fail_valid_i && fail_count_i == '0));

    // R7
    limit_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(stop_o) && reason_o == 2'b10) |-> (iter_o >= max_iter_i));

    // R8
    stop_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop_o && !start_i) |=> (stop_o && $stable(reason_o) && $stable(iter_o)));
endmodule

bind ldpc_stop_ctrl ldpc_stop_ctrl_chk #(.ITER_W(ITER_W), .FAIL_W(FAIL_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .start_i      (start_i),
    .max_iter_i   (max_iter_i),
    .fail_valid_i (fail_valid_i),
    .fail_count_i (fail_count_i),
    .stop_o       (stop_o),
    .reason_o     (reason_o),
    .iter_o       (iter_o)
);

// File: tb/ldpc_stop_ctrl_tb.sv
module ldpc_stop_ctrl_tb_top;
    localparam int unsigned BLK    = 2;
    localparam int unsigned ITER_W = 6;
    localparam int unsigned FAIL_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [2:0]        rate = '0;
    logic [ITER_W-1:0] max_iter = '0;
    logic              fvalid = 1'b0;
    logic [FAIL_W-1:0] fcount = '0;
    logic              bvalid = 1'b0;
    logic              bdata = 1'b0;
    logic              stop;
    logic [1:0]        reason;
    logic [ITER_W-1:0] iter;

    int checks = 0;
    int errors = 0;
    logic pay [0:127];
    logic [31:0] lfsr = 32'h1357_9BDF;

    always #4 clk = ~clk;

    ldpc_stop_ctrl #(.BLK_BITS(BLK), .ITER_W(ITER_W), .FAIL_W(FAIL_W)) dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .rate_i(rate),
        .max_iter_i(max_iter), .fail_valid_i(fvalid), .fail_count_i(fcount),
        .bit_valid_i(bvalid), .bit_i(bdata),
        .stop_o(stop), .reason_o(reason), .iter_o(iter)
    );

    function automatic int unsigned units(input int r);
        int unsigned u [8] = '{30, 36, 40, 45, 48, 50, 52, 54};
        return u[r];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic s, input logic [1:0] rs, input int it);
        chk({req, " stop"}, 32'(stop), 32'(s));
        chk({req, " reason"}, 32'(reason), 32'(rs));
        chk({req, " iter"}, 32'(iter), 32'(it));
    endtask

    task automatic begin_word(input int r, input int m);
        @(negedge clk);
        rate = 3'(r); max_iter = ITER_W'(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic report(input int cnt);
        @(negedge clk);
        fvalid = 1'b1; fcount = FAIL_W'(cnt);
        @(negedge clk);
        fvalid = 1'b0;
    endtask

    // fills pay with K-32 random bits followed by their CRC, one bit flipped if bad
    task automatic make_word(input int k, input bit bad);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < k - 32; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pay[i] = lfsr[0];
            c = {c[30:0], 1'b0} ^ ((c[31] ^ lfsr[0]) ? 32'h04C1_1DB7 : 32'h0);
        end
        for (int i = 0; i < 32; i++) pay[k - 32 + i] = c[31 - i];
        if (bad) pay[k / 2] = ~pay[k / 2];
    endtask

    task automatic send_bits(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            bvalid = 1'b1; bdata = pay[i];
        end
        @(negedge clk);
        bvalid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_state("R1 reset", 1'b0, 2'b00, 0);

        // R6 R5: every rate, good CRC on the first iteration
        for (int r = 0; r < 8; r++) begin
            int k;
            k = int'(units(r) * BLK);
            begin_word(r, 8);
            chk_state("R1 start", 1'b0, 2'b00, 0);
            report(10);
            chk_state("R4 window open, not stopped", 1'b0, 2'b00, 1);
            make_word(k, 1'b0);
            send_bits(k);
            chk_state("R5 R6 crc pass", 1'b1, 2'b01, 1);
        end

        // R10 then R7: bad CRC below limit, bad CRC at limit, every rate
        for (int r = 0; r < 8; r++) begin
            int k;
            k = int'(units(r) * BLK);
            begin_word(r, 2);
            report(1);
            make_word(k, 1'b1);
            send_bits(k);
            chk_state("R10 mismatch continues", 1'b0, 2'b00, 1);
            report(49);
            make_word(k, 1'b1);
            send_bits(k);
            chk_state("R7 mismatch at limit", 1'b1, 2'b10, 2);
        end

        // R5: bad CRC then good CRC on a later iteration
        begin_word(3, 5);
        report(20);
        make_word(90, 1'b1);
        send_bits(90);
        chk_state("R10 first mismatch", 1'b0, 2'b00, 1);
        report(20);
        make_word(90, 1'b0);
        send_bits(90);
        chk_state("R5 later pass", 1'b1, 2'b01, 2);

        // R3: zero failures stop at once with reason 00
        begin_word(0, 4);
        report(70);
        report(0);
        chk_state("R3 all checks pass", 1'b1, 2'b00, 2);

        // R8: reports and bits ignored once stopped
        report(0);
        report(10);
        make_word(60, 1'b0);
        send_bits(60);
        chk_state("R8 held after stop", 1'b1, 2'b00, 2);

        // R4 R9: count at threshold opens no window, stray bits ignored, 49 opens one
        begin_word(1, 10);
        report(50);
        chk_state("R4 at threshold", 1'b0, 2'b00, 1);
        make_word(72, 1'b0);
        send_bits(72);
        chk_state("R9 stray bits no effect", 1'b0, 2'b00, 1);
        report(49);
        send_bits(72);
        chk_state("R9 R5 window after stray bits", 1'b1, 2'b01, 2);

        // R7 R2: limit sweep with counts above threshold
        for (int m = 1; m <= 6; m++) begin
            begin_word(0, m);
            for (int n = 1; n <= m; n++) begin
                report(100 + n);
                if (n < m) chk_state("R2 R7 before limit", 1'b0, 2'b00, n);
            end
            chk_state("R7 limit reached", 1'b1, 2'b10, m);
        end

        // R7: limit zero acts as one
        begin_word(2, 0);
        report(300);
        chk_state("R7 zero limit", 1'b1, 2'b10, 1);

        // R3 priority at the limit: zero count wins over limit
        begin_word(2, 1);
        report(0);
        chk_state("R3 zero beats limit", 1'b1, 2'b00, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule